// File: doc/BRIEF.md
# Block Luma Motion Detector

This block watches a raster stream of 8-bit luma samples and reports, for every square tile of the picture, whether the tile's brightness has moved since the last frame that was examined. Each accepted sample carries a frame-start and a line-start marker. The block sums the samples of every tile and divides the sum by the tile area to get a mean. It compares this mean with the mean kept for the same tile from the previous detection frame. For each tile it then produces one 8-bit record.

The tile edge is 8 or 16 pixels. A record holds either a motion flag and a saturated 7-bit difference, or the motion flag alone. Detection can be limited to one frame out of two, three or four. The previous means are held in a small on-chip table. A sticky completion flag, cleared by a one-cycle clear strobe, marks the end of each detection pass.

Top module: `luma_motion_detector`

## Requirements
- R1: While `md_en` is low at the frame start, the frame produces no records and leaves `done_flag` untouched. Lowering `md_en` also resets the frame counter and the priming state.
- R2: When `cfg_blk8` is 0 the tiles are 16x16, giving FRAME_W/16 records per tile row. When `cfg_blk8` is 1 the tiles are 8x8, giving FRAME_W/8 records per tile row. Records come out in raster order of tiles: left to right within a tile row, tile rows top to bottom.
- R3: The tile mean is the integer sum of its samples divided by the tile area. With d = |current mean - stored mean|, record bit 7 is 1 exactly when d / 8 (integer division) is greater than `cfg_thresh`.
- R4: When `cfg_flag_only` is 0, record bits 6:0 hold min(d, 127). When it is 1, bits 6:0 are 0.
- R5: A counter starts at 0 when the detector is enabled and steps at each frame start, wrapping after `cfg_every`. A frame is a detection frame when the counter is 0 at its start, so detection runs once every `cfg_every`+1 frames.
- R6: The first detection frame after enabling emits its full set of records as all-zero bytes. It stores every tile mean for later comparison.
- R7: The records of one tile row come out on consecutive clock cycles, after the last sample of that tile row.
- R8: `done_pulse` is high in the same cycle as the last record of a detection frame, and `done_flag` sets on the next cycle. `done_flag` stays set until `done_clr` is high, and a set in the same cycle wins over the clear.
- R9: Tile size, record format and threshold are captured at the frame start. Changing them during a frame does not affect that frame's records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| md_en | input | 1 | Detection enable |
| cfg_blk8 | input | 1 | Tile size select: 0 = 16x16, 1 = 8x8 |
| cfg_flag_only | input | 1 | Record format: 1 = motion flag only |
| cfg_every | input | 2 | Detection period minus one, in frames |
| cfg_thresh | input | 5 | Motion threshold on d/8 |
| pix_valid | input | 1 | Sample valid |
| pix_sof | input | 1 | First sample of a frame |
| pix_sol | input | 1 | First sample of a line |
| pix_luma | input | 8 | Luma sample |
| done_clr | input | 1 | Clears the completion flag |
| rec_valid | output | 1 | Record valid |
| rec_data | output | 8 | Record: bit 7 motion, bits 6:0 magnitude or zero |
| done_pulse | output | 1 | Last record of a detection pass |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The embedded properties check several things on every cycle. They check that records of a priming frame are zero and that the flag-only format clears the magnitude. They check that a difference below 8 never raises the motion bit and that the emit column stays within the row. They also check that non-detection frame starts stay inactive and that the completion flag holds and clears as specified. Only the bench scenarios can show the arithmetic of the tile means. The same holds for saturation at 127, the period of the frame counter across several frames, the per-row record count and the capture of configuration at the frame start. The bench does this by comparing every record against a tile-sum model of the same picture.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
   localparam int LUMA_W = 8;
   localparam int SUM_W  = 16;
   localparam int THR_W  = 5;

   typedef struct packed {
      logic       moved;
      logic [6:0] mag;
   } lmd_rec_t;

   function automatic logic [7:0] abs_diff(input logic [7:0] a, input logic [7:0] b);
      return (a >= b) ? (a - b) : (b - a);
   endfunction

   function automatic logic [6:0] sat7(input logic [7:0] d);
      return d[7] ? 7'h7f : d[6:0];
   endfunction
endpackage

// File: rtl/lmd_scan.sv
module lmd_scan #(
   parameter int FRAME_W = 32,
   parameter int FRAME_H = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               blk8,
   input  logic                               pix_valid,
   input  logic                               pix_sof,
   input  logic                               pix_sol,
   output logic                               row_done,
   output logic                               frame_end,
   output logic                               fresh,
   output logic [$clog2(FRAME_W/8)-1:0]       blk_col,
   output logic [$clog2(FRAME_H/8)-1:0]       blk_row
);
   localparam int XW = $clog2(FRAME_W);
   localparam int YW = $clog2(FRAME_H);
   localparam int CW = $clog2(FRAME_W/8);
   localparam int RW = $clog2(FRAME_H/8);

   logic [XW-1:0] nx, cx;
   logic [YW-1:0] ny, cy;
   logic [3:0]    mask, in_x, in_y;
   logic          last_x, last_y;

   always_comb begin
      mask   = blk8 ? 4'd7 : 4'd15;
      cx     = (pix_sof || pix_sol) ? '0 : nx;
      if (pix_sof)                   cy = '0;
      else if (pix_sol && nx != '0)  cy = ny + YW'(1);
      else                           cy = ny;
      in_x      = cx[3:0] & mask;
      in_y      = cy[3:0] & mask;
      last_x    = (cx == XW'(FRAME_W - 1));
      last_y    = (cy == YW'(FRAME_H - 1));
      row_done  = pix_valid && last_x && (in_y == mask);
      frame_end = row_done && last_y;
      fresh     = (in_x == 4'd0) && (in_y == 4'd0);
      blk_col   = blk8 ? CW'(cx >> 3) : CW'(cx >> 4);
      blk_row   = blk8 ? RW'(cy >> 3) : RW'(cy >> 4);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nx <= '0;
         ny <= '0;
      end else if (pix_valid) begin
         if (last_x) begin
            nx <= '0;
            ny <= last_y ? '0 : cy + YW'(1);
         end else begin
            nx <= cx + XW'(1);
            ny <= cy;
         end
      end
   end

   assert_row_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> row_done && (blk_row != '0 || FRAME_H <= 16));
endmodule

// File: rtl/lmd_accum.sv
module lmd_accum
   import lmd_pkg::*;
#(
   parameter int NCOL = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pix_valid,
   input  logic                      fresh,
   input  logic [$clog2(NCOL)-1:0]   blk_col,
   input  logic [LUMA_W-1:0]         luma,
   output logic [SUM_W-1:0]          sums [NCOL]
);
   localparam int CW = $clog2(NCOL);

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      logic [SUM_W-1:0] acc;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            acc <= '0;
         else if (pix_valid && blk_col == CW'(c))
            acc <= fresh ? SUM_W'(luma) : acc + SUM_W'(luma);
      end
      assign sums[c] = acc;
   end
endmodule

// File: rtl/lmd_emit.sv
module lmd_emit
   import lmd_pkg::*;
#(
   parameter int NCOL = 4,
   parameter int NROW = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      start_last,
   input  logic [$clog2(NROW)-1:0]   start_row,
   input  logic                      blk8,
   input  logic                      flag_only,
   input  logic [THR_W-1:0]          thresh,
   input  logic                      act,
   input  logic                      first,
   input  logic [SUM_W-1:0]          sums [NCOL],
   output logic                      rec_valid,
   output logic [7:0]                rec_data,
   output logic                      pass_done
);
   localparam int CW    = $clog2(NCOL);
   localparam int RW    = $clog2(NROW);
   localparam int DEPTH = NCOL * NROW;
   localparam int AW    = $clog2(DEPTH);

   logic             busy, last_q;
   logic [CW-1:0]    col, last_col;
   logic [RW-1:0]    row_q;
   logic             e_blk8, e_flag, e_act, e_first;
   logic [THR_W-1:0] e_thr;
   logic [SUM_W-1:0] sel;
   logic [7:0]       mean, prev, diff;
   logic [AW-1:0]    idx;
   logic [7:0]       mem [DEPTH];
   lmd_rec_t         rec;

   always_comb begin
      last_col = e_blk8 ? CW'(NCOL - 1) : CW'(NCOL/2 - 1);
      sel      = sums[col];
      mean     = e_blk8 ? sel[13:6] : sel[15:8];
      idx      = AW'(int'(row_q) * NCOL + int'(col));
      prev     = mem[idx];
      diff     = abs_diff(mean, prev);
      rec.moved = (diff[7:3] > e_thr);
      rec.mag   = e_flag ? 7'd0 : sat7(diff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; col <= '0; row_q <= '0; last_q <= 1'b0;
         e_blk8 <= 1'b0; e_flag <= 1'b0; e_act <= 1'b0; e_first <= 1'b0; e_thr <= '0;
      end else if (start) begin
         busy <= 1'b1; col <= '0; row_q <= start_row; last_q <= start_last;
         e_blk8 <= blk8; e_flag <= flag_only; e_act <= act; e_first <= first; e_thr <= thresh;
      end else if (busy) begin
         if (col == last_col) busy <= 1'b0;
         else                 col  <= col + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (busy && e_act) mem[idx] <= mean;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_valid <= 1'b0;
         rec_data  <= '0;
         pass_done <= 1'b0;
      end else begin
         rec_valid <= busy && e_act;
         rec_data  <= e_first ? 8'd0 : rec;
         pass_done <= busy && e_act && last_q && (col == last_col);
      end
   end

   assert_first_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && e_first |-> rec_data == 8'd0);
   assert_flag_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && e_flag |-> rec_data[6:0] == 7'd0);
   assert_small_diff_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !e_flag && rec_data[6:0] < 7'd8 |-> !rec_data[7]);
   assert_col_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> col <= last_col);
endmodule

// File: rtl/luma_motion_detector.sv
module luma_motion_detector
   import lmd_pkg::*;
#(
   parameter int FRAME_W = 32,
   parameter int FRAME_H = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       md_en,
   input  logic       cfg_blk8,
   input  logic       cfg_flag_only,
   input  logic [1:0] cfg_every,
   input  logic [4:0] cfg_thresh,
   input  logic       pix_valid,
   input  logic       pix_sof,
   input  logic       pix_sol,
   input  logic [7:0] pix_luma,
   input  logic       done_clr,
   output logic       rec_valid,
   output logic [7:0] rec_data,
   output logic       done_pulse,
   output logic       done_flag
);
   localparam int NCOL = FRAME_W / 8;
   localparam int NROW = FRAME_H / 8;
   localparam int CW   = $clog2(NCOL);
   localparam int RW   = $clog2(NROW);

   if (FRAME_W % 16 != 0 || FRAME_H % 16 != 0 || FRAME_W < 16 || FRAME_H < 16) begin : g_bad_geom
      $error("frame width and height must be non-zero multiples of 16");
   end

   logic             f_blk8, f_flag, f_act, f_first, primed;
   logic [THR_W-1:0] f_thr;
   logic [1:0]       cnt;
   logic             row_done, frame_end, fresh, pass_done;
   logic [CW-1:0]    blk_col;
   logic [RW-1:0]    blk_row;
   logic [SUM_W-1:0] sums [NCOL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_blk8 <= 1'b0; f_flag <= 1'b0; f_act <= 1'b0; f_first <= 1'b0;
         f_thr <= '0; cnt <= '0; primed <= 1'b0;
      end else begin
         if (!md_en) begin
            cnt    <= '0;
            primed <= 1'b0;
         end
         if (pix_valid && pix_sof) begin
            f_blk8 <= cfg_blk8;
            f_flag <= cfg_flag_only;
            f_thr  <= cfg_thresh;
            if (md_en) begin
               f_act   <= (cnt == 2'd0);
               f_first <= !primed;
               if (cnt == 2'd0) primed <= 1'b1;
               cnt <= (cnt == cfg_every) ? 2'd0 : cnt + 2'd1;
            end else begin
               f_act <= 1'b0;
            end
         end
      end
   end

   lmd_scan #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) i_scan (
      .clk(clk), .rst_n(rst_n), .blk8(f_blk8), .pix_valid(pix_valid),
      .pix_sof(pix_sof), .pix_sol(pix_sol), .row_done(row_done),
      .frame_end(frame_end), .fresh(fresh), .blk_col(blk_col), .blk_row(blk_row));

   lmd_accum #(.NCOL(NCOL)) i_accum (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .fresh(fresh),
      .blk_col(blk_col), .luma(pix_luma), .sums(sums));

   lmd_emit #(.NCOL(NCOL), .NROW(NROW)) i_emit (
      .clk(clk), .rst_n(rst_n), .start(row_done), .start_last(frame_end),
      .start_row(blk_row), .blk8(f_blk8), .flag_only(f_flag), .thresh(f_thr),
      .act(f_act), .first(f_first), .sums(sums), .rec_valid(rec_valid),
      .rec_data(rec_data), .pass_done(pass_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         done_flag <= 1'b0;
      else if (pass_done) done_flag <= 1'b1;
      else if (done_clr)  done_flag <= 1'b0;
   end
   assign done_pulse = pass_done;

   assert_skip_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && pix_sof && md_en && cnt != 2'd0 |=> !f_act);
   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag && !done_clr |=> done_flag);
   assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag && done_clr && !done_pulse |=> !done_flag);
   assert_pulse_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> done_flag);
endmodule

// File: tb/test_luma_motion_detector.sv
module test_luma_motion_detector;
   localparam int W = 32;
   localparam int H = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic md_en = 1'b0, cfg_blk8 = 1'b0, cfg_flag_only = 1'b0;
   logic [1:0] cfg_every = 2'd0;
   logic [4:0] cfg_thresh = 5'd0;
   logic pix_valid = 1'b0, pix_sof = 1'b0, pix_sol = 1'b0;
   logic [7:0] pix_luma = 8'd0;
   logic done_clr = 1'b0;
   logic rec_valid, done_pulse, done_flag;
   logic [7:0] rec_data;

   always #5 clk = ~clk;

   luma_motion_detector #(.FRAME_W(W), .FRAME_H(H)) i_luma_motion_detector (
      .clk(clk), .rst_n(rst_n), .md_en(md_en), .cfg_blk8(cfg_blk8),
      .cfg_flag_only(cfg_flag_only), .cfg_every(cfg_every), .cfg_thresh(cfg_thresh),
      .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_sol(pix_sol), .pix_luma(pix_luma),
      .done_clr(done_clr), .rec_valid(rec_valid), .rec_data(rec_data),
      .done_pulse(done_pulse), .done_flag(done_flag));

   int total = 0, bad = 0;
   int exp_q[$];
   string tag_q[$];
   int prev_mean[64];
   int m_cnt = 0, m_primed = 0;
   int exp_ncols = 2;
   int run = 0, recs_seen = 0;
   int img[H][W];

   task automatic check(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int pat(input int kind, input int val, input int x, input int y);
      if (kind == 0) return val;
      return ((x/4)*13 + (y/4)*29 + val*37*(((x/8)+(y/8))%3) + val*5) % 256;
   endfunction

   // every clock: compare records against the model queue, and check run lengths (R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (rec_valid) begin
            run++;
            recs_seen++;
            if (exp_q.size() == 0) begin
               check("R1", 1, 0, "unexpected record");
            end else begin
               check(tag_q.pop_front(), rec_data, exp_q.pop_front(), "record");
            end
         end else if (run > 0) begin
            check("R7", run, exp_ncols, "records per tile row");
            run = 0;
         end
      end
   end

   task automatic run_frame(input int kind, input int val, input bit en, input bit b8,
                            input bit fo, input int every, input int thr,
                            input bit gaps, input int thr_mid);
      int act, first, bs, nc, nr, sum, mean, d, rec, expected;
      string tg;
      for (int y = 0; y < H; y++)
         for (int x = 0; x < W; x++)
            img[y][x] = pat(kind, val, x, y);
      act = 0; first = 0;
      if (en) begin
         act = (m_cnt == 0);
         first = !m_primed;
         if (act) m_primed = 1;
         m_cnt = (m_cnt == every) ? 0 : m_cnt + 1;
      end else begin
         m_cnt = 0; m_primed = 0;
      end
      bs = b8 ? 8 : 16;
      nc = W / bs; nr = H / bs;
      exp_ncols = nc;
      expected = 0;
      if (act) begin
         for (int br = 0; br < nr; br++)
            for (int bc = 0; bc < nc; bc++) begin
               sum = 0;
               for (int yy = 0; yy < bs; yy++)
                  for (int xx = 0; xx < bs; xx++)
                     sum += img[br*bs+yy][bc*bs+xx];
               mean = sum / (bs*bs);
               d = mean - prev_mean[br*(W/8)+bc];
               if (d < 0) d = -d;
               if (first) begin
                  rec = 0; tg = "R6";
               end else begin
                  rec = ((d/8) > thr) ? 128 : 0;
                  if (!fo) rec += (d > 127) ? 127 : d;
                  tg = (thr_mid >= 0) ? "R9" : (fo ? "R4" : "R3");
               end
               exp_q.push_back(rec);
               tag_q.push_back(tg);
               prev_mean[br*(W/8)+bc] = mean;
               expected++;
            end
      end
      recs_seen = 0;
      @(negedge clk);
      md_en = en; cfg_blk8 = b8; cfg_flag_only = fo;
      cfg_every = 2'(every); cfg_thresh = 5'(thr);
      for (int y = 0; y < H; y++)
         for (int x = 0; x < W; x++) begin
            if (gaps && ((x + y) % 5 == 0)) begin
               pix_valid = 1'b0;
               @(negedge clk);
            end
            if (thr_mid >= 0 && y == 5 && x == 0) begin
               cfg_thresh = 5'(thr_mid);
               cfg_blk8 = ~b8;
            end
            pix_valid = 1'b1;
            pix_sof = (x == 0 && y == 0);
            pix_sol = (x == 0);
            pix_luma = 8'(img[y][x]);
            @(negedge clk);
         end
      pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0;
      cfg_blk8 = b8;
      repeat (20) @(negedge clk);
      check("R2", recs_seen, expected, "records in frame");
      check(act ? "R8" : "R5", done_flag, act, "done flag after frame");
      if (done_flag) begin
         done_clr = 1'b1;
         @(negedge clk);
         done_clr = 1'b0;
         check("R8", done_flag, 0, "done flag after clear");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) prev_mean[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", done_flag, 0, "reset done flag");
      check("R1", rec_valid, 0, "reset record valid");
      // R1: disabled frame
      run_frame(1, 3, 0, 0, 0, 0, 0, 0, -1);
      // R6 priming, then R3/R4 with 16x16 tiles
      run_frame(0, 0, 1, 0, 0, 0, 2, 0, -1);
      run_frame(0, 255, 1, 0, 0, 0, 2, 0, -1);
      run_frame(1, 1, 1, 0, 0, 0, 2, 0, -1);
      run_frame(1, 2, 1, 0, 0, 0, 1, 1, -1);
      run_frame(1, 3, 1, 0, 1, 0, 0, 0, -1);
      // R9: threshold and tile size changed mid-frame
      run_frame(1, 4, 1, 0, 0, 0, 0, 0, 31);
      // R2: 8x8 tiles after re-enable
      run_frame(1, 5, 0, 1, 0, 0, 0, 0, -1);
      run_frame(1, 5, 1, 1, 0, 0, 0, 0, -1);
      run_frame(1, 6, 1, 1, 0, 0, 31, 0, -1);
      run_frame(0, 200, 1, 1, 0, 0, 0, 1, -1);
      run_frame(1, 7, 1, 1, 1, 0, 3, 0, -1);
      // R5: every third frame, then every fourth
      run_frame(0, 0, 0, 0, 0, 2, 0, 0, -1);
      for (int f = 0; f < 7; f++) run_frame(1, 8 + f, 1, 0, 0, 2, 1, 0, -1);
      run_frame(0, 0, 0, 1, 0, 3, 0, 0, -1);
      for (int f = 0; f < 5; f++) run_frame(1, 20 + f, 1, 1, 0, 3, 2, 0, -1);
      check("R2", exp_q.size(), 0, "records left over");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule